// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Gating Unit

This block sits beside a processor's retire stage and decides, each time an instruction boundary is signalled, which pending event may be taken there. Five kinds of event compete: a page or protection fault, a debug fault, a non-maskable interrupt, a maskable external interrupt and a single-step trap. At most one is granted per boundary, by a fixed priority. The block owns the interrupt-enable flag and the state of non-maskable interrupt service. A repeated string operation raises the boundary strobe between iterations, so events can be taken partway through a long string.

The retire interface gives a class code for the instruction that finishes at the boundary. Clearing and setting the flag explicitly are checked against privilege: when the current privilege level is numerically greater than the I/O privilege level, the flag is kept and a protection pulse is raised instead. A flag-word load takes the enable bit from a supplied word. Entry through a gate clears the flag. A boundary that ends a stack-segment load is shadowed: only faults may be taken there. The flag value that gates the external interrupt is the one after the retiring instruction has acted.

There are two enumerated state machines. The NMI tracker has states NMI_IDLE, NMI_PEND and NMI_SERVE. It moves NMI_IDLE→NMI_PEND on a rising edge of the NMI line, NMI_PEND→NMI_SERVE when the NMI is granted, and NMI_SERVE→NMI_IDLE when an interrupt return retires at a boundary. Edges seen in NMI_PEND or NMI_SERVE are dropped. The flag unit has states IEF_OFF and IEF_ON. It moves IEF_OFF→IEF_ON on a permitted set, or on a flag load with the bit at 1. It moves IEF_ON→IEF_OFF on a permitted clear, a flag load with the bit at 0, or a gate entry. Reset enters IEF_OFF.

Top module: `irq_boundary_gate`

## Requirements
- R1: The accept vector is all zero in every cycle where the boundary strobe is low.
- R2: The accept vector has at most one bit set. Bit 0 is fault, bit 1 debug, bit 2 NMI, bit 3 INTR and bit 4 single-step. When several are eligible, the lowest bit number wins.
- R3: After reset the flag output is 0. INTR is granted only when the flag is 1.
- R4: Class 1 clears the flag and class 2 sets it, but only when CPL <= IOPL. Otherwise the flag is unchanged and the protection pulse is 1 at that boundary. Class 0 is an ordinary instruction and has no effect.
- R5: Class 3 (flag-word load) and class 4 (interrupt return) load the flag from bit 9 of the flags word. Class 6 (gate entry) clears the flag.
- R6: NMI is recognised on a rising edge of its line and stays pending until it is granted. A line held high does not request again.
- R7: After an NMI is granted, further NMI edges are ignored until a class 4 instruction retires at a boundary.
- R8: At a boundary with class 5 (stack-segment load), NMI, INTR, debug and single-step are not granted, but a fault still is. A pending NMI stays pending.
- R9: The shadow covers only the boundary at which the stack-segment load retires. The next boundary grants normally.
- R10: A debug request is not granted while the resume flag input is 1.
- R11: INTR gating uses the flag value after the retiring instruction's effect at the same boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bnd_i | input | 1 | Instruction-boundary strobe |
| ret_cls_i | input | 3 | Class code of the instruction retiring at this boundary |
| cpl_i | input | 2 | Current privilege level |
| iopl_i | input | 2 | I/O privilege level |
| flags_i | input | 32 | Flags word used by flag loads; bit 9 is the enable bit |
| nmi_i | input | 1 | Raw NMI request line |
| intr_i | input | 1 | Level-sensitive external interrupt request |
| flt_req_i | input | 1 | Page or protection fault request |
| dbg_req_i | input | 1 | Debug fault request |
| rf_i | input | 1 | Resume flag; suppresses the debug fault |
| step_req_i | input | 1 | Single-step trap request |
| acc_o | output | 5 | One-hot accept vector for this boundary |
| gp_o | output | 1 | Protection pulse for a refused flag clear or set |
| if_o | output | 1 | Registered interrupt-enable flag |

## Verification
A wrong flag state appears on the next boundary that carries an INTR request, as a missing or extra bit 3 in the accept vector. It also shows on if_o one clock after the faulty update. A wrong NMI state shows as a duplicate NMI grant, a lost pending NMI after a shadowed boundary, or a missing grant after an interrupt return. None of these is visible until the next boundary that has an NMI edge behind it. So the bench puts such a boundary directly after each state change.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    typedef enum logic [2:0] {
        CLS_OTHER = 3'd0,
        CLS_CLI   = 3'd1,
        CLS_STI   = 3'd2,
        CLS_POPF  = 3'd3,
        CLS_IRET  = 3'd4,
        CLS_SSLD  = 3'd5,
        CLS_GATE  = 3'd6,
        CLS_RSVD  = 3'd7
    } rcls_e;

    localparam int ACC_W    = 5;
    localparam int ACC_FLT  = 0;
    localparam int ACC_DBG  = 1;
    localparam int ACC_NMI  = 2;
    localparam int ACC_INT  = 3;
    localparam int ACC_STEP = 4;

    typedef enum logic [1:0] {
        NMI_IDLE  = 2'd0,
        NMI_PEND  = 2'd1,
        NMI_SERVE = 2'd2
    } nmi_st_e;

    typedef enum logic {
        IEF_OFF = 1'b0,
        IEF_ON  = 1'b1
    } ief_st_e;

endpackage

// File: rtl/irqg_nmi_track.sv
module irqg_nmi_track
    import irqg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic bnd_i,
    input  logic iret_i,
    input  logic take_i,
    output logic pend_o
);

    nmi_st_e st_q, st_d;
    logic    line_q;
    logic    rise;

    assign rise = nmi_i & ~line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= NMI_IDLE;
            line_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            line_q <= nmi_i;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            NMI_IDLE:  if (rise)           st_d = NMI_PEND;
            NMI_PEND:  if (take_i)         st_d = NMI_SERVE;
            NMI_SERVE: if (bnd_i && iret_i) st_d = NMI_IDLE;
            default:                        st_d = NMI_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (st_q == NMI_PEND);
    end

endmodule

// File: rtl/irqg_ie_flag.sv
module irqg_ie_flag
    import irqg_pkg::*;
#(
    parameter int PLW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bnd_i,
    input  rcls_e          cls_i,
    input  logic [PLW-1:0] cpl_i,
    input  logic [PLW-1:0] iopl_i,
    input  logic           ld_bit_i,
    output logic           if_post_o,
    output logic           if_o,
    output logic           gp_o
);

    ief_st_e st_q, st_d;
    logic    priv_ok;

    assign priv_ok = (cpl_i <= iopl_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IEF_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        gp_o = 1'b0;
        if (bnd_i) begin
            unique case (cls_i)
                CLS_CLI: begin
                    if (priv_ok) st_d = IEF_OFF;
                    else         gp_o = 1'b1;
                end
                CLS_STI: begin
                    if (priv_ok) st_d = IEF_ON;
                    else         gp_o = 1'b1;
                end
                CLS_POPF, CLS_IRET: st_d = ld_bit_i ? IEF_ON : IEF_OFF;
                CLS_GATE:           st_d = IEF_OFF;
                default:            st_d = st_q;
            endcase
        end
    end

    always_comb begin
        if_post_o = (st_d == IEF_ON);
        if_o      = (st_q == IEF_ON);
    end

endmodule

// File: rtl/irqg_arbiter.sv
module irqg_arbiter
    import irqg_pkg::*;
(
    input  logic             bnd_i,
    input  logic             shadow_i,
    input  logic [ACC_W-1:0] req_i,
    output logic [ACC_W-1:0] grant_o
);

    logic [ACC_W-1:0] mask;
    logic [ACC_W-1:0] elig;

    always_comb begin
        mask = {ACC_W{1'b1}};
        if (shadow_i) begin
            mask          = '0;
            mask[ACC_FLT] = 1'b1;
        end
        elig = bnd_i ? (req_i & mask) : '0;
    end

    genvar gi;
    generate
        for (gi = 0; gi < ACC_W; gi++) begin : g_pri
            if (gi == 0) begin : g_top
                assign grant_o[gi] = elig[gi];
            end else begin : g_rest
                assign grant_o[gi] = elig[gi] & ~(|elig[gi-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_boundary_gate.sv
module irq_boundary_gate
    import irqg_pkg::*;
#(
    parameter int FLAGW  = 32,
    parameter int IF_BIT = 9,
    parameter int PLW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_i,
    input  logic [2:0]       ret_cls_i,
    input  logic [PLW-1:0]   cpl_i,
    input  logic [PLW-1:0]   iopl_i,
    input  logic [FLAGW-1:0] flags_i,
    input  logic             nmi_i,
    input  logic             intr_i,
    input  logic             flt_req_i,
    input  logic             dbg_req_i,
    input  logic             rf_i,
    input  logic             step_req_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             gp_o,
    output logic             if_o
);

    rcls_e            cls;
    logic             if_post;
    logic             nmi_pend;
    logic             shadow;
    logic [ACC_W-1:0] req;
    logic             unused_flag_bits;

    assign cls              = rcls_e'(ret_cls_i);
    assign shadow           = bnd_i && (cls == CLS_SSLD);
    assign unused_flag_bits = ^flags_i;

    irqg_ie_flag #(.PLW(PLW)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd_i     (bnd_i),
        .cls_i     (cls),
        .cpl_i     (cpl_i),
        .iopl_i    (iopl_i),
        .ld_bit_i  (flags_i[IF_BIT]),
        .if_post_o (if_post),
        .if_o      (if_o),
        .gp_o      (gp_o)
    );

    irqg_nmi_track u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .bnd_i  (bnd_i),
        .iret_i (cls == CLS_IRET),
        .take_i (acc_o[ACC_NMI]),
        .pend_o (nmi_pend)
    );

    always_comb begin
        req           = '0;
        req[ACC_FLT]  = flt_req_i;
        req[ACC_DBG]  = dbg_req_i & ~rf_i;
        req[ACC_NMI]  = nmi_pend;
        req[ACC_INT]  = intr_i & if_post;
        req[ACC_STEP] = step_req_i;
    end

    irqg_arbiter u_arb (
        .bnd_i    (bnd_i),
        .shadow_i (shadow),
        .req_i    (req),
        .grant_o  (acc_o)
    );

endmodule

// File: rtl/irqg_checker.sv
module irqg_checker
    import irqg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bnd_i,
    input logic [2:0]       ret_cls_i,
    input logic             rf_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             gp_o,
    input logic             if_o
);

    logic in_serv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               in_serv_q <= 1'b0;
        else if (acc_o[ACC_NMI])                  in_serv_q <= 1'b1;
        else if (bnd_i && ret_cls_i == 3'd4)      in_serv_q <= 1'b0;
    end

    p_bnd_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_i |-> (acc_o == '0));

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_o));

    p_gp_keeps_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gp_o |=> $stable(if_o));

    p_gate_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && ret_cls_i == 3'd6) |=> !if_o);

    p_nmi_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o[ACC_NMI] |-> !in_serv_q);

    p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && ret_cls_i == 3'd5) |-> (acc_o[ACC_W-1:1] == '0));

    p_rf_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o[ACC_DBG] |-> !rf_i);

    p_intr_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o[ACC_INT] |=> if_o);

endmodule

bind irq_boundary_gate irqg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd_i     (bnd_i),
    .ret_cls_i (ret_cls_i),
    .rf_i      (rf_i),
    .acc_o     (acc_o),
    .gp_o      (gp_o),
    .if_o      (if_o)
);

// File: tb/irq_boundary_gate_bench.sv
module irq_boundary_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bnd_i = 1'b0;
    logic [2:0]  ret_cls_i = '0;
    logic [1:0]  cpl_i = '0;
    logic [1:0]  iopl_i = '0;
    logic [31:0] flags_i = '0;
    logic        nmi_i = 1'b0;
    logic        intr_i = 1'b0;
    logic        flt_req_i = 1'b0;
    logic        dbg_req_i = 1'b0;
    logic        rf_i = 1'b0;
    logic        step_req_i = 1'b0;
    logic [4:0]  acc_o;
    logic        gp_o;
    logic        if_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [4:0] s_acc;
    logic       s_gp;
    logic       s_if;

    always #10 clk = ~clk;

    irq_boundary_gate u_irq_boundary_gate (
        .clk(clk), .rst_n(rst_n), .bnd_i(bnd_i), .ret_cls_i(ret_cls_i),
        .cpl_i(cpl_i), .iopl_i(iopl_i), .flags_i(flags_i), .nmi_i(nmi_i),
        .intr_i(intr_i), .flt_req_i(flt_req_i), .dbg_req_i(dbg_req_i),
        .rf_i(rf_i), .step_req_i(step_req_i), .acc_o(acc_o), .gp_o(gp_o),
        .if_o(if_o)
    );

    // {cls, cpl, iopl, bit9, intr, flt, dbg, rf, step, acc, gp, if_after}
    function automatic logic [19:0] vec(
        input logic [2:0] c, input logic [1:0] cp, input logic [1:0] io,
        input logic f9, input logic it, input logic fl, input logic db,
        input logic r, input logic st, input logic [4:0] ea,
        input logic eg, input logic ei);
        return {c, cp, io, f9, it, fl, db, r, st, ea, eg, ei};
    endfunction

    localparam logic [19:0] TBL [16] = '{
        vec(3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0), // R3 flag off
        vec(3'd2, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01000, 1'b0, 1'b1), // R4 R11 set
        vec(3'd1, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01000, 1'b1, 1'b1), // R4 refused clear
        vec(3'd1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0), // R4 R11 clear
        vec(3'd2, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0), // R4 refused set
        vec(3'd3, 2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01000, 1'b0, 1'b1), // R5 load 1
        vec(3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'b00001, 1'b0, 1'b1), // R2 fault first
        vec(3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'b00010, 1'b0, 1'b1), // R2 debug next
        vec(3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'b01000, 1'b0, 1'b1), // R10 resume
        vec(3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10000, 1'b0, 1'b1), // R2 step
        vec(3'd5, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'b00000, 1'b0, 1'b1), // R8 shadow
        vec(3'd5, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00001, 1'b0, 1'b1), // R8 fault passes
        vec(3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01000, 1'b0, 1'b1), // R9 one boundary
        vec(3'd6, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0), // R5 gate clears
        vec(3'd4, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10000, 1'b0, 1'b1), // R5 return loads 1
        vec(3'd3, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0)  // R5 R11 load 0
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic boundary(input logic [2:0] c, input logic [1:0] cp, input logic [1:0] io,
                            input logic f9, input logic it, input logic fl, input logic db,
                            input logic r, input logic st);
        @(negedge clk);
        bnd_i = 1'b1; ret_cls_i = c; cpl_i = cp; iopl_i = io;
        flags_i = '0; flags_i[9] = f9;
        intr_i = it; flt_req_i = fl; dbg_req_i = db; rf_i = r; step_req_i = st;
        #5;
        s_acc = acc_o;
        s_gp  = gp_o;
        @(posedge clk);
        #1;
        s_if = if_o;
        @(negedge clk);
        bnd_i = 1'b0; ret_cls_i = '0; intr_i = 1'b0; flt_req_i = 1'b0;
        dbg_req_i = 1'b0; rf_i = 1'b0; step_req_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R3 flag after reset", {31'b0, if_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        intr_i = 1'b1;
        #5;
        chk("R1 no grant without strobe after reset", {27'b0, acc_o}, 32'd0);
        intr_i = 1'b0;

        for (int i = 0; i < 16; i++) begin
            logic [19:0] e;
            e = TBL[i];
            boundary(e[19:17], e[16:15], e[14:13], e[12], e[11], e[10], e[9], e[8], e[7]);
            chk($sformatf("R2 R3 R4 R5 R8 R9 R10 R11 vector %0d accept", i), {27'b0, s_acc}, {27'b0, e[6:2]});
            chk($sformatf("R4 vector %0d protection pulse", i), {31'b0, s_gp}, {31'b0, e[1]});
            chk($sformatf("R3 R4 R5 vector %0d flag", i), {31'b0, s_if}, {31'b0, e[0]});
        end

        // an ordinary instruction at class 0 leaves the flag untouched (R4)
        boundary(3'd0, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 class 0 keeps flag", {31'b0, s_if}, 32'd0);

        // flag on for the NMI tests
        boundary(3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 set before NMI tests", {31'b0, s_if}, 32'd1);

        // R6: rising edge becomes pending, beats INTR (R2)
        @(negedge clk); nmi_i = 1'b1;
        boundary(3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 R2 NMI granted over INTR", {27'b0, s_acc}, 32'b00100);

        // R6: held level does not request again
        boundary(3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 held line no new grant", {27'b0, s_acc}, 32'd0);

        // R7: new edge in service is ignored
        @(negedge clk); nmi_i = 1'b0;
        @(negedge clk); nmi_i = 1'b1;
        boundary(3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 edge in service ignored", {27'b0, s_acc}, 32'b01000);
        boundary(3'd4, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 ignored edge not pending at return", {27'b0, s_acc}, 32'd0);

        // R8/R9: pending NMI survives a shadowed boundary
        @(negedge clk); nmi_i = 1'b0;
        @(negedge clk); nmi_i = 1'b1;
        boundary(3'd5, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 NMI and INTR held off in shadow", {27'b0, s_acc}, 32'd0);
        boundary(3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 R9 pending NMI granted after shadow", {27'b0, s_acc}, 32'b00100);

        // R1: flag on, INTR high, no strobe
        @(negedge clk);
        intr_i = 1'b1; step_req_i = 1'b1; flt_req_i = 1'b1;
        #5;
        chk("R1 no grant between boundaries", {27'b0, acc_o}, 32'd0);
        @(negedge clk);
        intr_i = 1'b0; step_req_i = 1'b0; flt_req_i = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule